// File: doc/BRIEF.md
# I2C Target Receive DMA Controller

This block is the receive side of an I2C target that works in packet mode. Software sets up a few registers: the block's own bus address, where the received bytes go in memory, how many bytes fit there, a command word, an interrupt mode word and a counter of received bytes. The bit-level shifter sits outside the block. It matches the address and reports each write transfer to the block as three kinds of one-cycle strobes: a write start, one strobe per data byte, and a stop.

After an accepted start, each data byte goes out on a one-byte memory write port. The write address starts at the programmed base and goes up by one for each byte. A working length that counts down protects the end of the buffer, and the byte counter that software can read goes up with each stored byte. At stop the block sets four completion status bits together. The interrupt output stays high for as long as any status bit is set. Status can be cleared in two ways: a bit-by-bit write-one-to-clear, or a packet-done acknowledge that clears the whole low group with one write.

Register select codes: 0 own address, 1 receive base, 2 receive length, 3 command, 4 interrupt mode, 5 status, 6 received count. Register reads are combinational. Event responses and memory writes come out of registers on the clock edge that samples the event.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: A start strobe while command bit 0 (receive DMA enable) is 0 is refused: one cycle later rsp_vld=1, rsp_ack=0 and rsp_err=1. A refused transfer stores no data bytes.
- R2: A start strobe while command bit 0 is 1 is accepted. It clears the received count to 0, loads the working address from the base register and the working length from length bits [15:0] plus one, and answers rsp_ack=1 one cycle later.
- R3: Each data byte accepted after a start is written with mem_we=1, mem_addr equal to the working address and mem_wdata equal to the byte, one cycle after its strobe. The working address then goes up by 1, the working length goes down by 1, the received count goes up by 1, and rsp_ack=1.
- R4: A stop strobe sets status bits 16 (packet done), 7 (address match), 4 (normal stop) and 2 (receive done). irq is 1 from the next cycle.
- R5: A write to the length register with bit 31 set changes only bits [15:0]. A write with bit 31 clear replaces the whole register.
- R6: A write to the command register with bit 31 set ORs the value into the register. A write with bit 31 clear replaces it.
- R7: When interrupt mode bit 0 is 1, writing status with bit 16 set while status bit 16 is set clears status bits [17:0], and a status write without bit 16 changes nothing. When mode bit 0 is 0, each status bit written as 1 is cleared.
- R8: irq is 1 exactly while the status register is non-zero. Any write to the received count register sets it to 0.
- R9: Once the working length has reached zero, further data bytes get rsp_ack=0 with mem_we=0, and the received count does not change.
- R10: Reset clears every register, drops irq and the response and memory strobes, and leaves no transfer active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ev_start | input | 1 | Write-transfer start strobe from the shifter |
| ev_byte | input | 1 | Data byte strobe |
| ev_data | input | 8 | Data byte received |
| ev_stop | input | 1 | Stop strobe |
| tgt_addr | output | 7 | Programmed own address, used by the shifter for matching |
| rsp_vld | output | 1 | Response to the last start or byte is valid |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_err | output | 1 | Start refused because DMA is disabled |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| irq | output | 1 | Interrupt, high while status is non-zero |

## Verification
The assertions take for granted that at most one of ev_start, ev_byte and ev_stop is high in any cycle. They also assume software writes to status or to the received count never land in the same cycle as an event. The bench drives every strobe for exactly one cycle, with idle cycles between them, and does its register writes only while the event lines are quiet. Under those conditions each property is answered by a single event or write.

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ev_start,
  input  logic          ev_byte,
  input  logic [7:0]    ev_data,
  input  logic          ev_stop,
  output logic [6:0]    tgt_addr,
  output logic          rsp_vld,
  output logic          rsp_ack,
  output logic          rsp_err,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          irq
);
  localparam int PD = 16;
  localparam logic [31:0] DONE_SET = 32'h0001_0094;
  localparam logic [31:0] KEEP_HI  = 32'hFFFC_0000;

  logic [31:0] r_own, r_base, r_len, r_cmd, r_ien, r_st, r_cnt;
  logic [AW-1:0] waddr;
  logic [LW:0]   wlen;
  logic          active;
  logic [31:0]   st_nx;

  wire wr_own  = reg_we && reg_sel == 3'd0;
  wire wr_base = reg_we && reg_sel == 3'd1;
  wire wr_len  = reg_we && reg_sel == 3'd2;
  wire wr_cmd  = reg_we && reg_sel == 3'd3;
  wire wr_ien  = reg_we && reg_sel == 3'd4;
  wire wr_st   = reg_we && reg_sel == 3'd5;
  wire wr_cnt  = reg_we && reg_sel == 3'd6;
  wire pkt_mode = r_ien[0];
  wire take     = ev_byte && active && wlen != '0;

  assign tgt_addr = r_own[6:0];
  assign irq      = |r_st;

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = r_own;
      3'd1: reg_rdata = r_base;
      3'd2: reg_rdata = r_len;
      3'd3: reg_rdata = r_cmd;
      3'd4: reg_rdata = r_ien;
      3'd5: reg_rdata = r_st;
      3'd6: reg_rdata = r_cnt;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    st_nx = r_st;
    if (wr_st) begin
      if (pkt_mode) begin
        if (r_st[PD] && reg_wdata[PD]) st_nx = r_st & KEEP_HI;
      end else begin
        st_nx = r_st & ~reg_wdata;
      end
    end
    if (ev_stop) st_nx = st_nx | DONE_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_own <= '0; r_base <= '0; r_len <= '0; r_cmd <= '0;
      r_ien <= '0; r_st <= '0; r_cnt <= '0;
      waddr <= '0; wlen <= '0; active <= 1'b0;
      rsp_vld <= 1'b0; rsp_ack <= 1'b0; rsp_err <= 1'b0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      rsp_vld <= 1'b0;
      rsp_ack <= 1'b0;
      rsp_err <= 1'b0;
      mem_we  <= 1'b0;
      r_st    <= st_nx;
      if (wr_own)  r_own  <= reg_wdata;
      if (wr_base) r_base <= reg_wdata;
      if (wr_ien)  r_ien  <= reg_wdata;
      if (wr_cnt)  r_cnt  <= '0;
      if (wr_len) begin
        if (reg_wdata[31]) r_len[LW-1:0] <= reg_wdata[LW-1:0];
        else               r_len <= reg_wdata;
      end
      if (wr_cmd) r_cmd <= reg_wdata[31] ? (r_cmd | reg_wdata) : reg_wdata;

      if (ev_start) begin
        rsp_vld <= 1'b1;
        if (r_cmd[0]) begin
          active  <= 1'b1;
          r_cnt   <= '0;
          waddr   <= r_base[AW-1:0];
          wlen    <= {1'b0, r_len[LW-1:0]} + 1'b1;
          rsp_ack <= 1'b1;
        end else begin
          active  <= 1'b0;
          rsp_err <= 1'b1;
        end
      end else if (ev_byte) begin
        rsp_vld <= 1'b1;
        if (take) begin
          mem_we    <= 1'b1;
          mem_addr  <= waddr;
          mem_wdata <= ev_data;
          waddr     <= waddr + 1'b1;
          wlen      <= wlen - 1'b1;
          r_cnt     <= r_cnt + 1'b1;
          rsp_ack   <= 1'b1;
        end
      end else if (ev_stop) begin
        active <= 1'b0;
      end
    end
  end

  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !r_cmd[0] |=> rsp_err && !rsp_ack); // R1
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> rsp_ack && rsp_vld); // R3
  AST_STOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> irq && r_st[PD]); // R4
  AST_PKT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && pkt_mode && r_st[PD] && reg_wdata[PD] && !ev_stop |=> r_st[17:0] == '0); // R7
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt && !ev_start && !ev_byte |=> r_cnt == '0); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte && wlen == '0 |=> !mem_we && !rsp_ack && $stable(r_cnt)); // R9
endmodule

// File: tb/sim_i2c_tgt_rx_dma.sv
module sim_i2c_tgt_rx_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ev_start = 1'b0, ev_byte = 1'b0, ev_stop = 1'b0;
  logic [7:0] ev_data = '0;
  logic [6:0] tgt_addr;
  logic rsp_vld, rsp_ack, rsp_err, mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_tgt_rx_dma u0 (.*);

  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b1, 8'h3C},
    {1'b1, 8'h81}, {1'b1, 8'h7E}, {1'b0, 8'h11}, {1'b0, 8'h22}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic ev(input int kind, input logic [7:0] d);
    @(negedge clk);
    ev_start = (kind == 0); ev_byte = (kind == 1); ev_stop = (kind == 2); ev_data = d;
    @(negedge clk);
    ev_start = 1'b0; ev_byte = 1'b0; ev_stop = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 7; i++) begin rd(3'(i), v); chk("R10 reg reset", v, 0); end
    chk("R10 irq reset", {31'b0, irq}, 0);
    chk("R10 rsp reset", {31'b0, rsp_vld}, 0);

    ev(0, 0);
    chk("R1 err", {31'b0, rsp_err}, 1);
    chk("R1 ack", {31'b0, rsp_ack}, 0);
    ev(1, 8'h42);
    chk("R1 no store", {31'b0, mem_we}, 0);

    wr(0, 32'h55); chk("R2 tgt addr", {25'b0, tgt_addr}, 32'h55);
    wr(1, 32'h1000);
    wr(3, 32'h1);
    wr(3, 32'h8000_0002); rd(3, v); chk("R6 or merge", v, 32'h8000_0003);
    wr(3, 32'h1);         rd(3, v); chk("R6 replace", v, 32'h1);
    wr(2, 32'h00AB_0009);
    wr(2, 32'h8000_0003); rd(2, v); chk("R5 trigger", v, 32'h00AB_0003);
    wr(2, 32'h8000_0005); rd(2, v); chk("R5 trigger2", v, 32'h00AB_0005);
    wr(2, 32'h0000_0005); rd(2, v); chk("R5 overwrite", v, 32'h5);

    ev(0, 0);
    chk("R2 ack", {31'b0, rsp_ack}, 1);
    rd(6, v); chk("R2 count clear", v, 0);
    for (int i = 0; i < 8; i++) begin
      ev(1, VEC[i][7:0]);
      if (VEC[i][8]) begin
        chk("R3 we", {31'b0, mem_we}, 1);
        chk("R3 addr", mem_addr, 32'h1000 + i);
        chk("R3 data", {24'b0, mem_wdata}, {24'b0, VEC[i][7:0]});
        chk("R3 ack", {31'b0, rsp_ack}, 1);
      end else begin
        chk("R9 no we", {31'b0, mem_we}, 0);
        chk("R9 nack", {31'b0, rsp_ack}, 0);
      end
      rd(6, v); chk("R3 R9 count", v, VEC[i][8] ? i + 1 : 6);
    end

    ev(2, 0);
    chk("R4 irq", {31'b0, irq}, 1);
    rd(5, v); chk("R4 status", v, 32'h0001_0094);
    wr(5, 32'h4); rd(5, v); chk("R7 w1c", v, 32'h0001_0090);
    chk("R8 irq held", {31'b0, irq}, 1);
    wr(5, 32'h0001_0090); rd(5, v); chk("R7 w1c all", v, 0);
    chk("R8 irq low", {31'b0, irq}, 0);
    wr(6, 32'h1234); rd(6, v); chk("R8 count write", v, 0);

    wr(4, 32'h1);
    ev(2, 0);
    wr(5, 32'h94); rd(5, v); chk("R7 pkt ignore", v, 32'h0001_0094);
    wr(5, 32'h0001_0000); rd(5, v); chk("R7 pkt clear", v, 0);
    chk("R7 irq", {31'b0, irq}, 0);

    ev(2, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5, v); chk("R10 status", v, 0);
    rd(3, v); chk("R10 cmd", v, 0);
    chk("R10 irq", {31'b0, irq}, 0);
    ev(1, 8'h99);
    chk("R10 idle nack", {31'b0, rsp_ack}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule